// File: doc/BRIEF.md
# Timer Output Flip-Flop Controller

This block owns the flip-flop behind a timer's output pin. While the timer is stopped, software can preset the flip-flop with a two-bit level command. Bit 1 of the command requests a high level and bit 0 requests a low level. Once the two-bit timer mode field leaves 00, the timer counts. From then on, every compare-match interrupt pulse from the counter inverts the flip-flop, starting from the level that was preset.

Software uses the block through two write strobes. The configuration write carries the output-operation enable, the pin enable, the level command and a write-one error clear. The mode write carries the timer mode. Some level commands break the configuration rules: a write while the timer runs, a write before output operation is enabled, or the reserved code 11. Such a command is discarded and latches a sticky error flag. Every rule is checked against the register values held before the clock edge on which the write lands. All state is registered on the rising clock edge, and both outputs follow the registers without further delay.

Top module: `tmr_out_ff_ctrl`

## Requirements
- R1: A configuration write with level code 2'b10 (set bit 1) makes the flip-flop high after the edge, provided the timer was stopped and output operation was already enabled.
- R2: Under the same conditions, level code 2'b01 (reset bit 0) makes the flip-flop low after the edge.
- R3: Level code 2'b00 leaves the flip-flop unchanged and raises no error, so the pin keeps the last preset level.
- R4: Mode 2'b00 means stopped and modes 2'b01, 2'b10 and 2'b11 mean running; interrupt pulses while stopped leave the pin unchanged.
- R5: A nonzero level command written while the stored mode is nonzero leaves the flip-flop unchanged and sets the error flag.
- R6: While the timer runs with output operation enabled, each interrupt pulse inverts the flip-flop on the next edge, starting from the preset level.
- R7: Level code 2'b11 is reserved: it never changes the flip-flop and always sets the error flag.
- R8: While output operation is disabled, level commands are discarded with the error flag set, and interrupt pulses do not toggle.
- R9: With the pin enable at 0 the pin is driven low, while the flip-flop keeps running internally and its level appears on the pin once the pin is enabled again.
- R10: The error flag stays set until a configuration write with the clear bit at 1; if a new error occurs on that same write, the flag stays set.
- R11: A synchronous active-low reset clears the flip-flop, the mode, both enables and the error flag.
- R12: A level command written in the same cycle as a mode write is judged against the mode held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| regWe | input | 1 | Configuration write strobe |
| opEnIn | input | 1 | Output-operation enable value to write |
| pinEnIn | input | 1 | Pin enable value to write |
| levelIn | input | 2 | Level command (bit 1 set, bit 0 reset) |
| errClrIn | input | 1 | Write 1 to clear the error flag |
| modeWe | input | 1 | Mode write strobe |
| modeIn | input | MODE_W | Timer mode value to write |
| cmpIrq | input | 1 | Compare-match interrupt pulse |
| pinOut | output | 1 | Timer output pin level |
| errFlag | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the block with MODE_W at its default of 2. At that width every mode code is reachable: the stopped code and all three running codes, so the toggle path is driven under each running code. The bench runs the same instance through writes that collide with mode changes and error clears. This brings the same-cycle ordering rules within reach alongside the ordinary preset and toggle paths.

// File: rtl/tffc_pkg.sv
package tffc_pkg;

  localparam logic [1:0] LVL_HOLD = 2'b00;
  localparam logic [1:0] LVL_LOW  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;
  localparam logic [1:0] LVL_RSV  = 2'b11;

  typedef struct packed {
    logic doSet;
    logic doClr;
    logic doToggle;
  } ffStrobe_t;

endpackage

// File: rtl/tffc_ctrl.sv
module tffc_ctrl
  import tffc_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              opEnIn,
  input  logic              pinEnIn,
  input  logic [1:0]        levelIn,
  input  logic              errClrIn,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              cmpIrq,
  output ffStrobe_t         strobe,
  output logic              pinEn,
  output logic              errFlag
);

  localparam logic [MODE_W-1:0] MODE_STOP = '0;

  logic [MODE_W-1:0] modeQ;
  logic              opEnQ;
  logic              pinEnQ;
  logic              errQ;
  logic              running;
  logic              cmdValid;
  logic              cmdBad;

  assign running  = (modeQ != MODE_STOP);
  assign cmdValid = regWe && (levelIn != LVL_HOLD);
  assign cmdBad   = cmdValid && (running || !opEnQ || (levelIn == LVL_RSV));

  always_comb begin
    strobe          = '0;
    strobe.doSet    = cmdValid && !cmdBad && (levelIn == LVL_HIGH);
    strobe.doClr    = cmdValid && !cmdBad && (levelIn == LVL_LOW);
    strobe.doToggle = cmpIrq && running && opEnQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_STOP;
      opEnQ  <= 1'b0;
      pinEnQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      if (modeWe) modeQ <= modeIn;
      if (regWe) begin
        opEnQ  <= opEnIn;
        pinEnQ <= pinEnIn;
      end
      if (cmdBad) errQ <= 1'b1;
      else if (regWe && errClrIn) errQ <= 1'b0;
    end
  end

  assign pinEn   = pinEnQ;
  assign errFlag = errQ;

  AST_LOCK_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (levelIn != LVL_HOLD) && running) |=> errFlag); // R5
  AST_RSV_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (levelIn == LVL_RSV)) |=> errFlag); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(regWe && errClrIn)) |=> errFlag); // R10
  AST_STOP_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !strobe.doToggle); // R4

endmodule

// File: rtl/tffc_dpath.sv
module tffc_dpath
  import tffc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ffStrobe_t strobe,
  input  logic      pinEn,
  output logic      pinOut
);

  logic ffQ;

  always_ff @(posedge clk) begin
    if (!rstN)               ffQ <= 1'b0;
    else if (strobe.doSet)    ffQ <= 1'b1;
    else if (strobe.doClr)    ffQ <= 1'b0;
    else if (strobe.doToggle) ffQ <= ~ffQ;
  end

  assign pinOut = pinEn & ffQ;

  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doSet |=> ffQ); // R1
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doClr |=> !ffQ); // R2
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doToggle |=> (ffQ != $past(ffQ))); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doSet || strobe.doClr || strobe.doToggle) |=> $stable(ffQ)); // R3

endmodule

// File: rtl/tmr_out_ff_ctrl.sv
module tmr_out_ff_ctrl
  import tffc_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              opEnIn,
  input  logic              pinEnIn,
  input  logic [1:0]        levelIn,
  input  logic              errClrIn,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              cmpIrq,
  output logic              pinOut,
  output logic              errFlag
);

  ffStrobe_t strobe;
  logic      pinEn;

  tffc_ctrl #(.MODE_W(MODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .opEnIn(opEnIn),
    .pinEnIn(pinEnIn), .levelIn(levelIn), .errClrIn(errClrIn),
    .modeWe(modeWe), .modeIn(modeIn), .cmpIrq(cmpIrq),
    .strobe(strobe), .pinEn(pinEn), .errFlag(errFlag)
  );

  tffc_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pinEn(pinEn), .pinOut(pinOut)
  );

  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !pinEnIn) |=> !pinOut); // R9

endmodule

// File: tb/tb_tmr_out_ff_ctrl.sv
module tb_tmr_out_ff_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MODE_W = 2;

  logic clk = 1'b0;
  logic rstN, regWe, opEnIn, pinEnIn, errClrIn, modeWe, cmpIrq;
  logic [1:0] levelIn;
  logic [MODE_W-1:0] modeIn;
  logic pinOut, errFlag;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  // behavioural reference state
  int mFf, mPinEn, mOpEn, mMode, mErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_out_ff_ctrl #(.MODE_W(MODE_W)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .opEnIn(opEnIn),
    .pinEnIn(pinEnIn), .levelIn(levelIn), .errClrIn(errClrIn),
    .modeWe(modeWe), .modeIn(modeIn), .cmpIrq(cmpIrq),
    .pinOut(pinOut), .errFlag(errFlag)
  );

  task automatic setIn(input bit we, input bit op, input bit pe, input int lvl,
                       input bit clr, input bit mwe, input int md, input bit irq);
    regWe = we; opEnIn = op; pinEnIn = pe; levelIn = 2'(lvl);
    errClrIn = clr; modeWe = mwe; modeIn = MODE_W'(md); cmpIrq = irq;
  endtask

  task automatic modelEdge();
    int lvl;
    bit bad;
    lvl = int'(levelIn);
    if (!rstN) begin
      mFf = 0; mPinEn = 0; mOpEn = 0; mMode = 0; mErr = 0;
    end else begin
      bad = regWe && lvl != 0 && (mMode != 0 || mOpEn == 0 || lvl == 3);
      if (regWe && lvl == 2 && !bad) mFf = 1;
      else if (regWe && lvl == 1 && !bad) mFf = 0;
      else if (cmpIrq && mMode != 0 && mOpEn != 0) mFf = 1 - mFf;
      if (bad) mErr = 1;
      else if (regWe && errClrIn) mErr = 0;
      if (regWe) begin mOpEn = opEnIn; mPinEn = pinEnIn; end
      if (modeWe) mMode = int'(modeIn);
    end
  endtask

  task automatic step(input string tag);
    int expPin;
    @(posedge clk);
    modelEdge();
    #1;
    expPin = mPinEn & mFf;
    nCmp++;
    if (int'(pinOut) != expPin || int'(errFlag) != mErr) begin
      nBad++;
      $display("FAIL %s: pinOut=%0d errFlag=%0d expected pinOut=%0d errFlag=%0d",
               tag, pinOut, errFlag, expPin, mErr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    setIn(0, 0, 0, 0, 0, 0, 0, 0);
    step("R11"); step("R11");
    rstN = 1'b1;
    step("R11");
    // command before output operation enabled
    setIn(1, 0, 1, 2, 0, 0, 0, 0); step("R8");
    setIn(0, 0, 0, 0, 0, 0, 0, 0); step("R8");
    setIn(1, 1, 1, 0, 1, 0, 0, 0); step("R10");
    setIn(1, 1, 1, 2, 0, 0, 0, 0); step("R1");
    setIn(1, 1, 1, 0, 0, 0, 0, 0); step("R3");
    setIn(0, 0, 0, 0, 0, 0, 0, 0); step("R3");
    setIn(1, 1, 1, 1, 0, 0, 0, 0); step("R2");
    setIn(1, 1, 1, 3, 0, 0, 0, 0); step("R7");
    setIn(1, 1, 1, 2, 1, 0, 0, 0); step("R10");
    setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R4");
    setIn(0, 0, 0, 0, 0, 1, 1, 0); step("R4");
    setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R6");
    setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R6");
    setIn(0, 0, 0, 0, 0, 0, 0, 0); step("R6");
    setIn(1, 1, 1, 1, 0, 0, 0, 0); step("R5");
    setIn(1, 1, 1, 2, 1, 0, 0, 0); step("R10");
    setIn(1, 1, 1, 0, 1, 0, 0, 0); step("R10");
    setIn(1, 1, 0, 0, 0, 0, 0, 0); step("R9");
    setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R9");
    setIn(1, 1, 1, 0, 0, 0, 0, 0); step("R9");
    for (int md = 2; md <= 3; md++) begin
      setIn(0, 0, 0, 0, 0, 1, md, 0); step("R4");
      setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R6");
      setIn(1, 1, 1, 3, 0, 0, 0, 1); step("R7");
      setIn(1, 1, 1, 0, 1, 0, 0, 0); step("R10");
    end
    // level write alongside mode stop: judged by old mode
    setIn(1, 1, 1, 1, 0, 1, 0, 0); step("R12");
    setIn(1, 1, 1, 1, 1, 0, 0, 0); step("R12");
    setIn(1, 1, 1, 2, 0, 1, 1, 0); step("R12");
    setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R6");
    setIn(1, 0, 1, 0, 0, 0, 0, 0); step("R8");
    setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R8");
    setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R8");
    setIn(1, 1, 1, 3, 0, 0, 0, 0); step("R7");
    rstN = 1'b0;
    setIn(0, 0, 0, 0, 0, 0, 0, 0); step("R11");
    rstN = 1'b1;
    setIn(0, 0, 0, 0, 0, 0, 0, 1); step("R11");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule